// File: doc/BRIEF.md
# Three-Mode Clock Power Manager

This block decides, cycle by cycle, which internal clock domains of a small processor subsystem receive clock pulses. It drives three clock enables (execution core, bus interface, peripherals), the matching gated clocks, and an enable for the crystal oscillator. Software selects one of three low-power states, or full-rate operation, through a mode write, and loads a divisor code and a wake-up delay through a separate settings write.

In power-save, the core and bus-interface enables pulse once per programmed divisor period while peripherals run at full rate. Idle stops the core and bus-interface domains and leaves peripherals running. Powerdown stops every domain and turns the oscillator off. An NMI, an interrupt whose mask bit is clear, or reset brings the block back to full rate. Leaving powerdown first restarts the oscillator and then holds every domain off for a programmed settling count.

Enables are registered on the falling source-clock edge. Each gated clock is the source clock ANDed with its enable, so a pulse is never cut short and a stopped clock always rests low.

Top module: `clock_power_manager`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, all three clock enables and the oscillator enable are high and the block is in full-rate mode. Reset also clears the divisor code to 0 and sets the wake delay to its reset value. Assertion of reset takes effect at once, without waiting for a clock edge.
- R2: Writing mode code 2'b01 from full rate enters power-save. The core and bus enables are then high for one source cycle out of every 2^k, starting with a high cycle right after the accepting edge. The peripheral and oscillator enables stay high throughout.
- R3: The divisor code k takes values 0 to 6, which divide by 1, 2, 4, 8, 16, 32 and 64. A code of 7 is stored as 6, which divides by 64.
- R4: A divisor code written while in power-save first lets the period already under way complete. The new period starts at the next divided-clock boundary.
- R5: Mode code 2'b10 (idle) holds the core and bus enables low and keeps the peripheral and oscillator enables high.
- R6: Mode code 2'b11 (powerdown) holds all three clock enables and the oscillator enable low. Mode code 2'b00 selects full rate.
- R7: In power-save or idle, an NMI or any request bit whose mask bit is 0 returns the block to full rate on the next cycle. A request whose mask bit is 1 has no effect.
- R8: In powerdown, a wake event raises only the oscillator enable on the next cycle. The clock enables return D+1 cycles later, where D is the stored wake delay.
- R9: Mode and settings writes are ignored in idle, in powerdown and during the wake-up wait. The stored divisor code and wake delay survive powerdown unchanged.
- R10: Enables change only while the source clock is low. Each gated clock equals the source clock ANDed with its enable, so it is low whenever the source clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWe | input | 1 | Mode write strobe |
| modeSel | input | 2 | Mode code: 00 full rate, 01 power-save, 10 idle, 11 powerdown |
| setWe | input | 1 | Settings write strobe (divisor code and wake delay) |
| divSel | input | 3 | Divisor code k, divide by 2^k |
| wakeDelay | input | 8 | Settling cycles after powerdown exit |
| irqReq | input | 4 | Interrupt request lines |
| irqMask | input | 4 | Per-line mask, 1 blocks wake-up |
| nmi | input | 1 | Non-maskable wake request |
| coreClkEn | output | 1 | Execution-core clock enable |
| busClkEn | output | 1 | Bus-interface clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| coreClk | output | 1 | Gated core clock |
| busClk | output | 1 | Gated bus-interface clock |
| periClk | output | 1 | Gated peripheral clock |

## Verification
The bench targets a divisor change that lands mid-period. A design that applies it at once would pulse the core too early and break the running period. It also checks the clamp of code 7: a design without it would wrap to a short period or a divide-by-128 counter. Wake-up from powerdown is counted cycle by cycle against a delay written before entry, with a different value written during powerdown. An off-by-one in the counter, or a write that leaks through while asleep, shifts when the clocks return. Masked requests, writes during idle, reset asserted in the middle of powerdown, and the enable level on both clock phases catch designs that wake too easily, ignore reset or let a gated clock glitch.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  localparam int NDOM     = 3;
  localparam int DOM_CORE = 0;
  localparam int DOM_BUS  = 1;
  localparam int DOM_PERI = 2;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_SAVE   = 3'd1,
    ST_IDLE   = 3'd2,
    ST_PDOWN  = 3'd3,
    ST_WAKE   = 3'd4
  } pmState_t;

  typedef enum logic [1:0] {
    MD_ACTIVE = 2'b00,
    MD_SAVE   = 2'b01,
    MD_IDLE   = 2'b10,
    MD_PDOWN  = 2'b11
  } modeCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setLoad;     // capture divisor code and wake delay
    logic divRestart;  // restart divider on power-save entry
    logic wakeLoad;    // load settling counter
    logic wakeCount;   // count settling counter down
  } pmStrobe_t;

endpackage

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int DIVSEL_W   = 3,
  parameter int MAX_DIVSEL = 6,
  parameter int WAKE_W     = 8,
  parameter int RST_WAKE   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pmStrobe_t           strobe,
  input  logic [DIVSEL_W-1:0] setDivSel,
  input  logic [WAKE_W-1:0]   setWake,
  output logic                divPulse,
  output logic                wakeDone
);

  localparam int CNT_W = (MAX_DIVSEL > 0) ? MAX_DIVSEL : 1;
  localparam logic [DIVSEL_W-1:0] SEL_MAX = DIVSEL_W'(MAX_DIVSEL);

  logic [DIVSEL_W-1:0] divSelReg;
  logic [DIVSEL_W-1:0] divSelEff;
  logic [DIVSEL_W-1:0] divSelClamped;
  logic [CNT_W-1:0]    divCnt;
  logic [CNT_W-1:0]    divLimit;
  logic [WAKE_W-1:0]   wakeDelayReg;
  logic [WAKE_W-1:0]   wakeCnt;

  assign divSelClamped = (setDivSel > SEL_MAX) ? SEL_MAX : setDivSel;

  // terminal count 2^eff - 1: bit b is set when b < eff
  for (genvar b = 0; b < CNT_W; b++) begin : g_limit
    assign divLimit[b] = (divSelEff > DIVSEL_W'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSelReg    <= '0;
      wakeDelayReg <= WAKE_W'(RST_WAKE);
    end else if (strobe.setLoad) begin
      divSelReg    <= divSelClamped;
      wakeDelayReg <= setWake;
    end
  end

  // divider: new code is picked up only at a period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      divSelEff <= '0;
    end else if (strobe.divRestart) begin
      divCnt    <= '0;
      divSelEff <= divSelReg;
    end else if (divCnt == divLimit) begin
      divCnt    <= '0;
      divSelEff <= divSelReg;
    end else begin
      divCnt    <= divCnt + 1'b1;
    end
  end

  assign divPulse = (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (strobe.wakeLoad) begin
      wakeCnt <= wakeDelayReg;
    end else if (strobe.wakeCount && (wakeCnt != '0)) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end

  assign wakeDone = (wakeCnt == '0);

endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeWe,
  input  logic [1:0]      modeSel,
  input  logic            setWe,
  input  logic [NIRQ-1:0] irqReq,
  input  logic [NIRQ-1:0] irqMask,
  input  logic            nmi,
  input  logic            divPulse,
  input  logic            wakeDone,
  output pmStrobe_t       strobe,
  output pmState_t        curState,
  output logic            wakeEvt,
  output logic [NDOM-1:0] enNext,
  output logic            oscNext
);

  pmState_t  nxtState;
  modeCode_t modeReq;
  logic      writable;

  assign wakeEvt  = nmi | (|(irqReq & ~irqMask));
  assign modeReq  = modeCode_t'(modeSel);
  assign writable = (curState == ST_ACTIVE) || (curState == ST_SAVE);

  always_comb begin
    nxtState          = curState;
    strobe            = '0;
    strobe.setLoad    = setWe && writable;
    unique case (curState)
      ST_ACTIVE: begin
        if (modeWe) begin
          unique case (modeReq)
            MD_SAVE: begin
              nxtState          = ST_SAVE;
              strobe.divRestart = 1'b1;
            end
            MD_IDLE:   nxtState = ST_IDLE;
            MD_PDOWN:  nxtState = ST_PDOWN;
            default:   nxtState = ST_ACTIVE;
          endcase
        end
      end
      ST_SAVE: begin
        if (wakeEvt) begin
          nxtState = ST_ACTIVE;
        end else if (modeWe) begin
          unique case (modeReq)
            MD_ACTIVE: nxtState = ST_ACTIVE;
            MD_IDLE:   nxtState = ST_IDLE;
            MD_PDOWN:  nxtState = ST_PDOWN;
            default:   nxtState = ST_SAVE;
          endcase
        end
      end
      ST_IDLE: begin
        if (wakeEvt) nxtState = ST_ACTIVE;
      end
      ST_PDOWN: begin
        if (wakeEvt) begin
          nxtState        = ST_WAKE;
          strobe.wakeLoad = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wakeDone) nxtState = ST_ACTIVE;
        else          strobe.wakeCount = 1'b1;
      end
      default: nxtState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_ACTIVE;
    else       curState <= nxtState;
  end

  always_comb begin
    enNext  = '0;
    oscNext = 1'b1;
    unique case (curState)
      ST_ACTIVE: enNext = '1;
      ST_SAVE: begin
        enNext[DOM_CORE] = divPulse;
        enNext[DOM_BUS]  = divPulse;
        enNext[DOM_PERI] = 1'b1;
      end
      ST_IDLE:  enNext[DOM_PERI] = 1'b1;
      ST_PDOWN: oscNext = 1'b0;
      ST_WAKE:  enNext = '0;
      default:  enNext = '1;
    endcase
  end

endmodule

// File: rtl/cpm_clkgate.sv
module cpm_clkgate
  import cpm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NDOM-1:0] enNext,
  input  logic            oscNext,
  output logic [NDOM-1:0] enOut,
  output logic [NDOM-1:0] gatedClk,
  output logic            oscOut
);

  // enables move on the falling edge, so AND gating never clips a pulse
  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic enQ;
    always_ff @(negedge clk or negedge rstN) begin
      if (!rstN) enQ <= 1'b1;
      else       enQ <= enNext[d];
    end
    assign enOut[d]    = enQ;
    assign gatedClk[d] = clk & enQ;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) oscOut <= 1'b1;
    else       oscOut <= oscNext;
  end

endmodule

// File: rtl/clock_power_manager.sv
module clock_power_manager
  import cpm_pkg::*;
#(
  parameter int NIRQ       = 4,
  parameter int DIVSEL_W   = 3,
  parameter int MAX_DIVSEL = 6,
  parameter int WAKE_W     = 8,
  parameter int RST_WAKE   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWe,
  input  logic [1:0]          modeSel,
  input  logic                setWe,
  input  logic [DIVSEL_W-1:0] divSel,
  input  logic [WAKE_W-1:0]   wakeDelay,
  input  logic [NIRQ-1:0]     irqReq,
  input  logic [NIRQ-1:0]     irqMask,
  input  logic                nmi,
  output logic                coreClkEn,
  output logic                busClkEn,
  output logic                periClkEn,
  output logic                oscEn,
  output logic                coreClk,
  output logic                busClk,
  output logic                periClk
);

  pmStrobe_t       strobe;
  pmState_t        curState;
  logic            wakeEvt;
  logic            divPulse;
  logic            wakeDone;
  logic [NDOM-1:0] enNext;
  logic            oscNext;
  logic [NDOM-1:0] enOut;
  logic [NDOM-1:0] gatedClk;

  cpm_ctrl #(.NIRQ(NIRQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeSel(modeSel), .setWe(setWe),
    .irqReq(irqReq), .irqMask(irqMask), .nmi(nmi), .divPulse(divPulse),
    .wakeDone(wakeDone), .strobe(strobe), .curState(curState), .wakeEvt(wakeEvt),
    .enNext(enNext), .oscNext(oscNext)
  );

  cpm_datapath #(
    .DIVSEL_W(DIVSEL_W), .MAX_DIVSEL(MAX_DIVSEL), .WAKE_W(WAKE_W), .RST_WAKE(RST_WAKE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setDivSel(divSel), .setWake(wakeDelay),
    .divPulse(divPulse), .wakeDone(wakeDone)
  );

  cpm_clkgate u_gate (
    .clk(clk), .rstN(rstN), .enNext(enNext), .oscNext(oscNext),
    .enOut(enOut), .gatedClk(gatedClk), .oscOut(oscEn)
  );

  assign coreClkEn = enOut[DOM_CORE];
  assign busClkEn  = enOut[DOM_BUS];
  assign periClkEn = enOut[DOM_PERI];
  assign coreClk   = gatedClk[DOM_CORE];
  assign busClk    = gatedClk[DOM_BUS];
  assign periClk   = gatedClk[DOM_PERI];

endmodule

// File: rtl/cpm_checker.sv
module cpm_checker
  import cpm_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input pmState_t curState,
  input logic     wakeEvt,
  input logic     coreClkEn,
  input logic     busClkEn,
  input logic     periClkEn,
  input logic     oscEn
);

  p_save_side_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_SAVE) |-> (periClkEn && oscEn && (coreClkEn == busClkEn)));

  p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE) |-> (!coreClkEn && !busClkEn && periClkEn && oscEn));

  p_pdown_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_PDOWN) |-> (!coreClkEn && !busClkEn && !periClkEn && !oscEn));

  p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (((curState == ST_SAVE) || (curState == ST_IDLE)) && wakeEvt) |=> (curState == ST_ACTIVE));

  p_pdown_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_PDOWN) && wakeEvt) |=> (curState == ST_WAKE));

  p_settle_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAKE) |-> (oscEn && !coreClkEn && !busClkEn && !periClkEn));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_IDLE) && !wakeEvt) |=> (curState == ST_IDLE));

  p_pdown_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_PDOWN) && !wakeEvt) |=> (curState == ST_PDOWN));

endmodule

bind clock_power_manager cpm_checker u_chk (
  .clk(clk), .rstN(rstN), .curState(curState), .wakeEvt(wakeEvt),
  .coreClkEn(coreClkEn), .busClkEn(busClkEn), .periClkEn(periClkEn), .oscEn(oscEn)
);

// File: tb/clock_power_manager_tb.sv
module clock_power_manager_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       modeWe, setWe, nmi;
  logic [1:0] modeSel;
  logic [2:0] divSel;
  logic [7:0] wakeDelay;
  logic [3:0] irqReq, irqMask;
  logic       coreClkEn, busClkEn, periClkEn, oscEn;
  logic       coreClk, busClk, periClk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [3:0] lastEn = 4'hF;

  always #2 clk = ~clk;

  clock_power_manager u_dut (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeSel(modeSel), .setWe(setWe),
    .divSel(divSel), .wakeDelay(wakeDelay), .irqReq(irqReq), .irqMask(irqMask),
    .nmi(nmi), .coreClkEn(coreClkEn), .busClkEn(busClkEn), .periClkEn(periClkEn),
    .oscEn(oscEn), .coreClk(coreClk), .busClk(busClk), .periClk(periClk)
  );

  // row: modeWe, mode, setWe, div, wake, irq, mask, nmi, expected {core,bus,peri,osc}
  function automatic logic [23:0] mk(input logic mw, input logic [1:0] md, input logic sw,
                                     input logic [2:0] dv, input logic [3:0] wk,
                                     input logic [3:0] iq, input logic [3:0] mk4,
                                     input logic nm, input logic [3:0] ex);
    return {mw, md, sw, dv, wk, iq, mk4, nm, ex};
  endfunction

  localparam int NVEC = 25;
  localparam logic [23:0] VEC [NVEC] = '{
    mk(0,2'd0,1,3'd2,4'd2,4'h0,4'h0,0,4'hF),  // R9 settings accepted at full rate
    mk(1,2'd2,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),  // R5 idle
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h1,4'h1,0,4'h3),  // R7 masked request
    mk(0,2'd0,0,3'd0,4'd0,4'h1,4'h0,0,4'hF),  // R7 unmasked request
    mk(1,2'd1,0,3'd0,4'd0,4'h0,4'h0,0,4'hF),  // R2 save, div 4
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'hF),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,1,4'hF),  // R7 nmi leaves save
    mk(1,2'd3,0,3'd0,4'd0,4'h0,4'h0,0,4'h0),  // R6 powerdown
    mk(0,2'd0,1,3'd0,4'd9,4'h0,4'h0,0,4'h0),  // R9 ignored settings
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h0),
    mk(0,2'd0,0,3'd0,4'd0,4'h2,4'h0,0,4'h1),  // R8 osc back first
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h1),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h1),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'hF),  // R8 after D+1
    mk(1,2'd1,0,3'd0,4'd0,4'h0,4'h0,0,4'hF),  // R9 retained div 4
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'h3),
    mk(0,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'hF),
    mk(1,2'd0,0,3'd0,4'd0,4'h0,4'h0,0,4'hF)
  };

  function automatic logic [3:0] en4();
    return {coreClkEn, busClkEn, periClkEn, oscEn};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: R10 checks on both phases, ends in the low phase
  task automatic step();
    @(posedge clk);
    #1;
    chk("R10", "enables held across rising edge", {28'd0, en4()}, {28'd0, lastEn});
    chk("R10", "gated clocks follow enables while high", {29'd0, coreClk, busClk, periClk},
        {29'd0, coreClkEn, busClkEn, periClkEn});
    #2;
    chk("R10", "gated clocks low in low phase", {29'd0, coreClk, busClk, periClk}, 32'd0);
    lastEn = en4();
  endtask

  task automatic cyc(input logic mw, input logic [1:0] md, input logic sw, input logic [2:0] dv,
                     input logic [7:0] wk, input logic [3:0] iq, input logic [3:0] mk4,
                     input logic nm);
    modeWe = mw; modeSel = md; setWe = sw; divSel = dv; wakeDelay = wk;
    irqReq = iq; irqMask = mk4; nmi = nm;
    step();
    modeWe = 0; setWe = 0; irqReq = '0; irqMask = '0; nmi = 0;
  endtask

  task automatic idleCyc();
    cyc(0, 2'd0, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pulses;
    int secondAt;
    rstN = 0; modeWe = 0; modeSel = 0; setWe = 0; divSel = 0; wakeDelay = 0;
    irqReq = 0; irqMask = 0; nmi = 0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1", "enables during reset", {28'd0, en4()}, 32'hF);
    rstN = 1;
    step();
    chk("R1", "enables after reset", {28'd0, en4()}, 32'hF);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      cyc(v[23], v[22:21], v[20], v[19:17], {4'd0, v[16:13]}, v[12:9], v[8:5], v[4]);
      chk("R2/R5/R6/R7/R8/R9", $sformatf("vector %0d", i), {28'd0, en4()}, {28'd0, v[3:0]});
    end

    // R4: divisor change mid-period waits for the boundary
    cyc(1, 2'd1, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    chk("R4", "save entry pulse", {31'd0, coreClkEn}, 32'd1);
    cyc(0, 2'd0, 1, 3'd1, 8'd2, 4'h0, 4'h0, 0);
    chk("R4", "write cycle", {31'd0, coreClkEn}, 32'd0);
    begin
      logic exp4 [5] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
      for (int i = 0; i < 5; i++) begin
        idleCyc();
        chk("R4", $sformatf("after change cycle %0d", i), {30'd0, coreClkEn, busClkEn},
            {30'd0, exp4[i], exp4[i]});
      end
    end
    cyc(1, 2'd0, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    chk("R6", "back to full rate", {28'd0, en4()}, 32'hF);

    // R3: code 7 clamps to divide by 64
    cyc(0, 2'd0, 1, 3'd7, 8'd2, 4'h0, 4'h0, 0);
    cyc(1, 2'd1, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    pulses = coreClkEn ? 1 : 0;
    secondAt = -1;
    for (int i = 1; i < 128; i++) begin
      idleCyc();
      if (coreClkEn) begin
        pulses++;
        if (secondAt < 0) secondAt = i;
      end
    end
    chk("R3", "pulses in 128 cycles at code 7", pulses, 2);
    chk("R3", "period at code 7", secondAt, 64);
    cyc(1, 2'd0, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);

    // R3: code 0 divides by 1
    cyc(0, 2'd0, 1, 3'd0, 8'd2, 4'h0, 4'h0, 0);
    cyc(1, 2'd1, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    pulses = coreClkEn ? 1 : 0;
    for (int i = 1; i < 8; i++) begin
      idleCyc();
      if (coreClkEn && busClkEn) pulses++;
    end
    chk("R3", "code 0 enables every cycle", pulses, 8);
    chk("R2", "peripherals run in save", {30'd0, periClkEn, oscEn}, 32'd3);

    // R9: mode write ignored in idle
    cyc(1, 2'd2, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    cyc(1, 2'd0, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    chk("R9", "idle ignores mode write", {28'd0, en4()}, 32'h3);
    cyc(0, 2'd0, 0, 3'd0, 8'd0, 4'h8, 4'h7, 0);
    chk("R7", "unmasked high line wakes idle", {28'd0, en4()}, 32'hF);

    // R1: reset in the middle of powerdown
    cyc(1, 2'd3, 0, 3'd0, 8'd0, 4'h0, 4'h0, 0);
    chk("R6", "powerdown before reset", {28'd0, en4()}, 32'h0);
    rstN = 0;
    #0.5;
    chk("R1", "reset restores enables at once", {28'd0, en4()}, 32'hF);
    @(posedge clk);
    #3;
    chk("R1", "held in reset", {28'd0, en4()}, 32'hF);
    rstN = 1;
    lastEn = 4'hF;
    step();
    chk("R1", "full rate after reset release", {28'd0, en4()}, 32'hF);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule